// File: doc/BRIEF.md
# Raster display timing generator

This block produces the horizontal sync, vertical sync, data enable and pixel clock strobe that drive a parallel RGB panel, together with the pixel column and row of the current active pixel. Software programs sync widths, porch widths and active sizes through a small register port. A programmable integer divider sets how many source clock cycles each pixel lasts.

Every line runs in a fixed order: sync, back porch, active pixels, front porch. Frames run in the same order of lines. Each of the four panel outputs has its own polarity inversion bit. A sticky frame status bit is set when the raster wraps into vertical sync. It is cleared by writing one to it, and a global enable gates it onto the interrupt pin.

Video runs only while two enable bits are both set. The immediate enable stops output on the next cycle. When the frame enable is cleared, the frame in progress completes first. All timing fields are stored as count minus one.

Top module: `raster_timing`

Register map (word addresses on `wr_addr`/`rd_addr`; every register reads back what was written, except address 4):
- 0 control: bit0 immediate enable, bit1 frame enable, bit2 invert hsync, bit3 invert vsync, bit4 invert data enable, bit5 invert pixel strobe, bit6 interrupt enable, bits 15:8 divider minus one.
- 1 horizontal: bits [PW-1:0] sync width minus one, [2PW-1:PW] back porch minus one, [3PW-1:2PW] front porch minus one.
- 2 vertical: the same three fields, counted in lines.
- 3 active size: bits [AW-1:0] pixels per line minus one, bits [16+AW-1:16] lines minus one.
- 4 status: bit0 frame flag. Writing 1 clears it and writing 0 has no effect.

## Requirements
- R1: After reset the register contents are zero, the status flag reads 0, and irq is 0. The outputs hsync, vsync, den and pclk are 0, and pix_x and pix_y are 0.
- R2: Within a line, hsync is active for the first (sync+1) pixels, and the back porch lasts (bp+1) pixels. The active span lasts (active+1) pixels and the front porch lasts (fp+1) pixels. The next line starts after the front porch.
- R3: Within a frame, vsync is active for the first (vsync+1) lines. The vertical back porch, active lines and front porch follow, each lasting its field plus one.
- R4: den is active only where the active columns of a line meet the active lines of the frame. pix_x is the offset from the first active column inside the active columns and 0 elsewhere, and pix_y is formed the same way for rows. den is never active together with hsync.
- R5: While running, the raw pixel strobe pulses once every (div+1) source cycles, with div the control field at bits 15:8. A field value of 255 gives a divisor of 255. All raster outputs hold still between strobes.
- R6: Inversion bits 2 to 5 of the control register each flip one output: hsync, vsync, den and pclk. The flip also applies while video is stopped, so a stopped output with its bit set reads 1.
- R7: The status flag is set in the cycle after the last pixel of a frame, when the raster wraps into vertical sync. The flag is set whatever the interrupt enable holds. irq equals the flag when control bit6 is 1, and is 0 otherwise.
- R8: Writing 1 to status bit0 clears the flag, and writing 0 leaves it unchanged. A frame wrap in the same cycle as a clearing write wins, and the flag stays set.
- R9: Clearing the immediate enable makes all outputs inactive from the next cycle. When video restarts, it starts at pixel 0 of line 0.
- R10: Video runs only while both enable bits are set. If the frame enable is cleared during a frame, the frame completes and the output then stops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | source clock |
| rst_n | input | 1 | active-low asynchronous reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | register write address |
| wr_data | input | 32 | register write data |
| rd_addr | input | 3 | register read address |
| rd_data | output | 32 | register read data (combinational) |
| hsync | output | 1 | horizontal sync |
| vsync | output | 1 | vertical sync |
| den | output | 1 | data enable |
| pclk | output | 1 | pixel clock strobe |
| pix_x | output | AW | column within the active area |
| pix_y | output | AW | row within the active area |
| irq | output | 1 | frame interrupt |

## Verification
The bench builds the block with its default parameters, PW=8 and AW=12, and programs short porches and a tiny active area. A whole frame then takes only 77 pixels, so every pixel of several frames can be compared against a model computed from the programmed counts. This covers every frame wrap, the status-flag timing, the mid-frame stop and the deferred stop. The full 8-bit divider field is still in reach, so the capped divisor of 255 is measured directly, along with a divisor of one and inverted polarities under a second timing set.

// File: rtl/raster_timing.sv
module raster_timing #(
  parameter int PW = 8,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [2:0]    rd_addr,
  output logic [31:0]   rd_data,
  output logic          hsync,
  output logic          vsync,
  output logic          den,
  output logic          pclk,
  output logic [AW-1:0] pix_x,
  output logic [AW-1:0] pix_y,
  output logic          irq
);
  localparam int CW = ((AW > PW) ? AW : PW) + 2;

  logic [31:0]   ctrl_q, htim_q, vtim_q, size_q;
  logic          stat_q, live_q;
  logic [7:0]    div_q;
  logic [CW-1:0] hcnt, vcnt;

  wire       en_now = ctrl_q[0];
  wire       en_frm = ctrl_q[1];
  wire [7:0] div_f  = ctrl_q[15:8];
  wire [7:0] div_eff = (div_f == 8'hFF) ? 8'hFE : div_f;
  wire       run  = en_now & live_q;
  wire       tick = run && (div_q >= div_eff);

  wire [CW-1:0] h_sync_last = CW'(htim_q[0+:PW]);
  wire [CW-1:0] h_start = CW'(htim_q[0+:PW]) + CW'(htim_q[PW+:PW]) + CW'(2);
  wire [CW-1:0] h_end   = h_start + CW'(size_q[0+:AW]);
  wire [CW-1:0] h_last  = h_end + CW'(htim_q[2*PW+:PW]) + CW'(1);

  wire [CW-1:0] v_sync_last = CW'(vtim_q[0+:PW]);
  wire [CW-1:0] v_start = CW'(vtim_q[0+:PW]) + CW'(vtim_q[PW+:PW]) + CW'(2);
  wire [CW-1:0] v_end   = v_start + CW'(size_q[16+:AW]);
  wire [CW-1:0] v_last  = v_end + CW'(vtim_q[2*PW+:PW]) + CW'(1);

  wire h_wrap    = (hcnt == h_last);
  wire v_wrap    = (vcnt == v_last);
  wire frame_end = tick & h_wrap & v_wrap;
  wire in_h      = (hcnt >= h_start) && (hcnt <= h_end);
  wire in_v      = (vcnt >= v_start) && (vcnt <= v_end);
  wire clr_stat  = wr_en && (wr_addr == 3'd4) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      htim_q <= '0;
      vtim_q <= '0;
      size_q <= '0;
      stat_q <= 1'b0;
      live_q <= 1'b0;
      div_q  <= '0;
      hcnt   <= '0;
      vcnt   <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          3'd0: ctrl_q <= wr_data;
          3'd1: htim_q <= wr_data;
          3'd2: vtim_q <= wr_data;
          3'd3: size_q <= wr_data;
          default: ;
        endcase
      end
      if (frame_end)     stat_q <= 1'b1;
      else if (clr_stat) stat_q <= 1'b0;
      if (en_frm)                  live_q <= 1'b1;
      else if (!run || frame_end)  live_q <= 1'b0;
      if (!run) begin
        div_q <= '0;
        hcnt  <= '0;
        vcnt  <= '0;
      end else if (tick) begin
        div_q <= '0;
        if (h_wrap) begin
          hcnt <= '0;
          vcnt <= v_wrap ? '0 : vcnt + CW'(1);
        end else begin
          hcnt <= hcnt + CW'(1);
        end
      end else begin
        div_q <= div_q + 8'd1;
      end
    end
  end

  assign hsync = (run & (hcnt <= h_sync_last)) ^ ctrl_q[2];
  assign vsync = (run & (vcnt <= v_sync_last)) ^ ctrl_q[3];
  assign den   = (run & in_h & in_v) ^ ctrl_q[4];
  assign pclk  = tick ^ ctrl_q[5];
  assign pix_x = (run & in_h) ? AW'(hcnt - h_start) : '0;
  assign pix_y = (run & in_v) ? AW'(vcnt - v_start) : '0;
  assign irq   = stat_q & ctrl_q[6];

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = ctrl_q;
      3'd1:    rd_data = htim_q;
      3'd2:    rd_data = vtim_q;
      3'd3:    rd_data = size_q;
      3'd4:    rd_data = {31'd0, stat_q};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          frame_end,
  input logic          stat_q,
  input logic          en_now,
  input logic          inv_hs,
  input logic          inv_de,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic          wr_bit0,
  input logic          hsync,
  input logic          den,
  input logic [AW-1:0] pix_x
);
  p_den_off_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (den ^ inv_de) |-> !(hsync ^ inv_hs));

  p_pix_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(pix_x));

  p_status_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> stat_q);

  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd4 && wr_bit0 && !frame_end) |=> !stat_q);

  p_stop_now_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_now |-> (!tick && !(den ^ inv_de)));
endmodule

bind raster_timing raster_timing_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .frame_end(frame_end),
  .stat_q(stat_q), .en_now(ctrl_q[0]), .inv_hs(ctrl_q[2]),
  .inv_de(ctrl_q[4]), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_bit0(wr_data[0]), .hsync(hsync), .den(den), .pix_x(pix_x)
);

// File: tb/tb_raster_timing.sv
module tb_raster_timing;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic hsync, vsync, den, pclk, irq;
  logic [AW-1:0] pix_x, pix_y;

  raster_timing #(.PW(8), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .hsync(hsync), .vsync(vsync), .den(den), .pclk(pclk),
    .pix_x(pix_x), .pix_y(pix_y), .irq(irq)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic hs, vs, de;
    logic [AW-1:0] x, y;
  } exp_t;

  exp_t sb[$];
  int total = 0, fails = 0, ticks = 0;
  bit mon_on = 1'b1;
  bit ihs = 0, ivs = 0, ide = 0, ipc = 0;
  string cur_req = "R2 R3 R4";
  int hs_n, hbp_n, hact_n, hfp_n, vs_n, vbp_n, vact_n, vfp_n;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  always @(negedge clk) begin
    if (rst_n && mon_on && (pclk ^ ipc)) begin
      ticks++;
      if (sb.size() > 0) begin
        exp_t e, o;
        e = sb.pop_front();
        o.hs = hsync ^ ihs;
        o.vs = vsync ^ ivs;
        o.de = den ^ ide;
        o.x = pix_x;
        o.y = pix_y;
        chk(o == e, cur_req, "pixel {hs,vs,de,x,y}", longint'(o), longint'(e));
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic logic [31:0] mk_ctrl(bit en, bit ef, bit a, bit b, bit c,
                                          bit p, bit ie, logic [7:0] dv);
    return {16'd0, dv, 1'b0, ie, p, c, b, a, ef, en};
  endfunction

  task automatic set_timing(int a, int b, int c, int d, int e, int f, int g, int h);
    hs_n = a; hbp_n = b; hact_n = c; hfp_n = d;
    vs_n = e; vbp_n = f; vact_n = g; vfp_n = h;
    wr(3'd1, 32'((hfp_n - 1) << 16 | (hbp_n - 1) << 8 | (hs_n - 1)));
    wr(3'd2, 32'((vfp_n - 1) << 16 | (vbp_n - 1) << 8 | (vs_n - 1)));
    wr(3'd3, 32'((vact_n - 1) << 16 | (hact_n - 1)));
  endtask

  task automatic push_frames(int n);
    int ht, vt, hst, vst;
    ht = hs_n + hbp_n + hact_n + hfp_n;
    vt = vs_n + vbp_n + vact_n + vfp_n;
    hst = hs_n + hbp_n;
    vst = vs_n + vbp_n;
    for (int f = 0; f < n; f++)
      for (int v = 0; v < vt; v++)
        for (int h = 0; h < ht; h++) begin
          exp_t e;
          bit hin, vin;
          hin = (h >= hst) && (h < hst + hact_n);
          vin = (v >= vst) && (v < vst + vact_n);
          e.hs = (h < hs_n);
          e.vs = (v < vs_n);
          e.de = hin && vin;
          e.x = hin ? AW'(h - hst) : '0;
          e.y = vin ? AW'(v - vst) : '0;
          sb.push_back(e);
        end
  endtask

  task automatic wait_empty();
    while (sb.size() > 0) @(negedge clk);
  endtask

  task automatic measure_period(output int p);
    p = 0;
    @(negedge clk);
    while (!(pclk ^ ipc)) @(negedge clk);
    @(negedge clk);
    p = 1;
    while (!(pclk ^ ipc)) begin
      @(negedge clk);
      p++;
    end
  endtask

  initial begin
    logic [31:0] d;
    int p, t0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(hsync == 0 && vsync == 0 && den == 0 && pclk == 0, "R1", "outputs idle",
        {hsync, vsync, den, pclk}, 0);
    chk(pix_x == 0 && pix_y == 0, "R1", "pixel position", {pix_x, pix_y}, 0);
    chk(irq == 0, "R1", "irq", irq, 0);
    rd(3'd4, d);
    chk(d == 0, "R1", "status", d, 0);
    rd(3'd0, d);
    chk(d == 0, "R1", "control", d, 0);

    // R2 R3 R4: two frames, divisor 2
    set_timing(2, 3, 4, 2, 1, 2, 3, 1);
    cur_req = "R2 R3 R4";
    push_frames(2);
    wr(3'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 8'd1));
    repeat (40) @(negedge clk);
    rd(3'd4, d);
    chk(d[0] == 0, "R7", "status inside first frame", d[0], 0);
    wait_empty();
    repeat (2) @(negedge clk);
    rd(3'd4, d);
    chk(d[0] == 1, "R7", "status after frame wrap", d[0], 1);
    chk(irq == 0, "R7", "irq while disabled", irq, 0);

    // R9 immediate stop, interrupt enabled
    wr(3'd0, mk_ctrl(0, 0, 0, 0, 0, 0, 1, 8'd1));
    chk(den == 0 && hsync == 0 && pclk == 0, "R9", "outputs after stop",
        {den, hsync, pclk}, 0);
    chk(irq == 1, "R7", "irq when enabled", irq, 1);
    wr(3'd4, 32'd0);
    rd(3'd4, d);
    chk(d[0] == 1, "R8", "status after writing 0", d[0], 1);
    wr(3'd4, 32'd1);
    rd(3'd4, d);
    chk(d[0] == 0, "R8", "status after writing 1", d[0], 0);
    chk(irq == 0, "R8", "irq after clear", irq, 0);

    // R5 divider
    wr(3'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 8'd3));
    measure_period(p);
    chk(p == 4, "R5", "strobe period, field 3", p, 4);
    wr(3'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 8'd255));
    measure_period(p);
    chk(p == 255, "R5", "strobe period, field 255", p, 255);
    wr(3'd0, mk_ctrl(0, 0, 0, 0, 0, 0, 0, 8'd0));

    // R6 polarity, second timing set, divisor 1
    mon_on = 0;
    set_timing(1, 1, 6, 3, 2, 1, 2, 2);
    wr(3'd0, mk_ctrl(0, 0, 1, 1, 1, 1, 0, 8'd0));
    @(negedge clk);
    chk(hsync && vsync && den && pclk, "R6", "inverted idle levels",
        {hsync, vsync, den, pclk}, 15);
    ihs = 1; ivs = 1; ide = 1; ipc = 1;
    mon_on = 1;
    cur_req = "R6 R2 R3 R4";
    push_frames(1);
    wr(3'd0, mk_ctrl(1, 1, 1, 1, 1, 1, 0, 8'd0));
    wait_empty();
    mon_on = 0;
    wr(3'd0, mk_ctrl(0, 0, 0, 0, 0, 0, 0, 8'd1));
    ihs = 0; ivs = 0; ide = 0; ipc = 0;
    @(negedge clk);
    mon_on = 1;

    // R9 mid-frame stop, restart from origin
    set_timing(2, 3, 4, 2, 1, 2, 3, 1);
    cur_req = "R9";
    push_frames(1);
    t0 = ticks;
    wr(3'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 8'd1));
    while (ticks < t0 + 30) @(negedge clk);
    wr(3'd0, mk_ctrl(0, 1, 0, 0, 0, 0, 0, 8'd1));
    chk(pix_x == 0 && pix_y == 0 && vsync == 0, "R9", "position after stop",
        {pix_x, pix_y, vsync}, 0);
    t0 = ticks;
    repeat (100) @(negedge clk);
    chk(ticks == t0, "R9", "strobes while stopped", ticks - t0, 0);
    sb.delete();
    push_frames(1);
    wr(3'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 8'd1));
    wait_empty();
    wr(3'd0, mk_ctrl(0, 0, 0, 0, 0, 0, 0, 8'd1));

    // R10 deferred stop
    cur_req = "R10";
    push_frames(1);
    t0 = ticks;
    wr(3'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 8'd1));
    while (ticks < t0 + 30) @(negedge clk);
    wr(3'd0, mk_ctrl(1, 0, 0, 0, 0, 0, 0, 8'd1));
    wait_empty();
    repeat (200) @(negedge clk);
    chk(ticks - t0 == 77, "R10", "strobes after frame enable cleared", ticks - t0, 77);
    chk(den == 0 && hsync == 0, "R10", "outputs after deferred stop", {den, hsync}, 0);
    finish_up();
  end
endmodule